// File: doc/BRIEF.md
# Isochronous Fixed-Chunk FIFO Gate

This block sits between the packet engine of an isochronous OUT endpoint and an external FIFO. It groups the incoming payload bytes into fixed chunks of 32 bytes. Each chunk stands for one application frame, so a chunk is written to the FIFO whole or not at all. Chunk boundaries never slip. When the FIFO has too little room, the entire chunk is thrown away and a one-cycle drop pulse is raised. When a packet ends part-way through a chunk, a one-cycle misalignment pulse is raised and the partial bytes are discarded. As a result the FIFO only ever holds complete chunks.

The room decision is taken once, on the first byte of a chunk, and it holds for all bytes of that chunk. Accepted bytes are staged in one half of a two-bank buffer. When the last byte of the chunk arrives, the whole chunk drains into the FIFO as one burst while the other bank fills. A saturating counter records the number of dropped chunks. A build-time parameter removes the chunking: every valid byte is then written straight through one cycle later, with no drop or alignment checks.

Top module: `iso_chunk_gate`

## Requirements
- R1: After reset, fifo_wr, drop_pulse and misalign_pulse are low and drop_count is zero.
- R2: A kept chunk is written in byte order as 32 consecutive fifo_wr cycles. The burst starts in the cycle after the chunk's 32nd byte is accepted.
- R3: On the first byte of a chunk, the chunk is kept only if fifo_free is at least 32 plus the number of bytes already committed but not yet written. Later changes of fifo_free during that chunk do not alter the decision.
- R4: No byte of a dropped chunk is ever written. drop_pulse is high for exactly the one cycle after the chunk's first byte is accepted.
- R5: If in_eop marks a byte that is not the 32nd byte of its chunk, misalign_pulse is high for the one cycle after that byte, and the bytes of that partial chunk are never written.
- R6: A byte with in_sop set is always byte 0 of a new chunk. Any partial chunk in progress is discarded without a misalignment pulse.
- R7: drop_count rises by one for each drop pulse, stays at 65535 once it gets there, and returns to zero on reset.
- R8: With chunking disabled, each byte accepted with in_valid is written, with its data, in the next cycle. No pulses are raised and drop_count stays zero.
- R9: Cycles with in_valid low neither advance the chunk position nor write anything for the stalled chunk. A chunk spread over gaps is handled the same as a contiguous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A payload byte is present this cycle |
| in_data | input | 8 | Payload byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| fifo_free | input | 10 | Free byte count reported by the FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| drop_pulse | output | 1 | One-cycle pulse per discarded chunk |
| misalign_pulse | output | 1 | One-cycle pulse per packet ending mid-chunk |
| drop_count | output | 16 | Saturating count of discarded chunks |

## Verification
The hardest case to reach is the room check made while the previous chunk is still draining. In that case the bytes still owed to the FIFO must count against the free space. The stimulus sends a 64-byte packet with only slightly more than one chunk of room, so the second chunk's first byte arrives just as the first burst begins. A second hard case is counter saturation, which needs more than 65535 drops. It is reached by streaming single-byte packets with no room, so each cycle produces one drop. Cycle-level agreement with a queue-based reference model covers the burst timing throughout.

// File: rtl/iso_chunk_pkg.sv
package iso_chunk_pkg;

    // Per-byte decisions produced by the chunk tracker
    typedef struct packed {
        logic store;     // byte goes into the fill bank
        logic commit;    // byte completes a kept chunk
        logic drop;      // chunk rejected on its first byte
        logic misalign;  // packet ended part-way through a chunk
    } chunk_evt_t;

    // Room test: a chunk fits only if space covers it plus bytes still owed
    function automatic logic chunk_fits(input int unsigned free_bytes,
                                        input int unsigned owed_bytes,
                                        input int unsigned chunk_bytes);
        return free_bytes >= (chunk_bytes + owed_bytes);
    endfunction

endpackage

// File: rtl/iso_chunk_tracker.sv
module iso_chunk_tracker
    import iso_chunk_pkg::*;
#(
    parameter int CHUNK_BYTES = 32,
    parameter int FREE_W      = 10,
    localparam int POS_W      = $clog2(CHUNK_BYTES),
    localparam int PEND_W     = $clog2(CHUNK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic [PEND_W-1:0] owed,
    output logic [POS_W-1:0]  slot,
    output chunk_evt_t        evt
);
    logic [POS_W-1:0] pos_q;
    logic             keep_q;
    logic [POS_W-1:0] eff_pos;
    logic             first_byte;
    logic             last_byte;
    logic             room;
    logic             keep_now;

    assign eff_pos    = in_sop ? '0 : pos_q;
    assign first_byte = in_valid && (eff_pos == '0);
    assign last_byte  = (eff_pos == POS_W'(CHUNK_BYTES - 1));
    assign room       = chunk_fits(32'(fifo_free), 32'(owed), 32'(CHUNK_BYTES));
    assign keep_now   = first_byte ? room : keep_q;
    assign slot       = eff_pos;

    always_comb begin
        evt          = '0;
        evt.store    = in_valid && keep_now;
        evt.commit   = in_valid && keep_now && last_byte;
        evt.drop     = first_byte && !room;
        evt.misalign = in_valid && in_eop && !last_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            keep_q <= 1'b0;
        end else if (in_valid) begin
            keep_q <= keep_now;
            if (in_eop || last_byte) pos_q <= '0;
            else                     pos_q <= eff_pos + 1'b1;
        end
    end
endmodule

// File: rtl/iso_chunk_buffer.sv
module iso_chunk_buffer #(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 32,
    localparam int POS_W      = $clog2(CHUNK_BYTES),
    localparam int PEND_W     = $clog2(CHUNK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store,
    input  logic              commit,
    input  logic [POS_W-1:0]  slot,
    input  logic [DATA_W-1:0] wdata,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic [PEND_W-1:0] owed
);
    logic [DATA_W-1:0] bank_mem [2][CHUNK_BYTES];
    logic              fill_sel;
    logic              drain_sel;
    logic              drain_on;
    logic [POS_W-1:0]  drain_idx;

    // Ping-pong storage: one bank fills while the other drains
    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (store && (fill_sel == 1'(b))) bank_mem[b][slot] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_sel  <= 1'b0;
            drain_sel <= 1'b0;
            drain_on  <= 1'b0;
            drain_idx <= '0;
        end else if (commit) begin
            drain_on  <= 1'b1;
            drain_idx <= '0;
            drain_sel <= fill_sel;
            fill_sel  <= ~fill_sel;
        end else if (drain_on) begin
            if (drain_idx == POS_W'(CHUNK_BYTES - 1)) drain_on <= 1'b0;
            drain_idx <= drain_idx + 1'b1;
        end
    end

    assign fifo_wr    = drain_on;
    assign fifo_wdata = bank_mem[drain_sel][drain_idx];
    assign owed       = drain_on ? (PEND_W'(CHUNK_BYTES) - PEND_W'(drain_idx)) : '0;
endmodule

// File: rtl/iso_sat_counter.sv
module iso_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (inc && (count != '1)) count <= count + 1'b1;
    end
endmodule

// File: rtl/iso_chunk_gate.sv
module iso_chunk_gate
    import iso_chunk_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 32,
    parameter int FREE_W      = 10,
    parameter int CNT_W       = 16,
    parameter bit CHUNKING_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              drop_pulse,
    output logic              misalign_pulse,
    output logic [CNT_W-1:0]  drop_count
);
    localparam int POS_W  = $clog2(CHUNK_BYTES);
    localparam int PEND_W = $clog2(CHUNK_BYTES + 1);

    logic cnt_inc;

    if (CHUNKING_EN) begin : g_chunked
        chunk_evt_t       evt;
        logic [POS_W-1:0] slot;
        logic [PEND_W-1:0] owed;
        logic             drop_q;
        logic             mis_q;

        iso_chunk_tracker #(.CHUNK_BYTES(CHUNK_BYTES), .FREE_W(FREE_W)) trk_i (
            .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
            .in_eop(in_eop), .fifo_free(fifo_free), .owed(owed),
            .slot(slot), .evt(evt)
        );

        iso_chunk_buffer #(.DATA_W(DATA_W), .CHUNK_BYTES(CHUNK_BYTES)) buf_i (
            .clk(clk), .rst(rst), .store(evt.store), .commit(evt.commit),
            .slot(slot), .wdata(in_data), .fifo_wr(fifo_wr),
            .fifo_wdata(fifo_wdata), .owed(owed)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                drop_q <= 1'b0;
                mis_q  <= 1'b0;
            end else begin
                drop_q <= evt.drop;
                mis_q  <= evt.misalign;
            end
        end

        assign drop_pulse     = drop_q;
        assign misalign_pulse = mis_q;
        assign cnt_inc        = evt.drop;
    end else begin : g_passthru
        logic              wr_q;
        logic [DATA_W-1:0] data_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                wr_q   <= 1'b0;
                data_q <= '0;
            end else begin
                wr_q   <= in_valid;
                data_q <= in_data;
            end
        end

        assign fifo_wr        = wr_q;
        assign fifo_wdata     = data_q;
        assign drop_pulse     = 1'b0;
        assign misalign_pulse = 1'b0;
        assign cnt_inc        = 1'b0;
    end

    iso_sat_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .inc(cnt_inc), .count(drop_count)
    );
endmodule

// File: rtl/iso_chunk_gate_chk.sv
module iso_chunk_gate_chk #(
    parameter int CHUNK_BYTES = 32,
    parameter int CNT_W       = 16,
    parameter bit CHUNKING_EN = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_eop,
    input logic             fifo_wr,
    input logic             drop_pulse,
    input logic             misalign_pulse,
    input logic [CNT_W-1:0] drop_count
);
    localparam int POS_W = $clog2(CHUNK_BYTES);

    logic [POS_W-1:0] wr_mod;
    always_ff @(posedge clk) begin
        if (rst)          wr_mod <= '0;
        else if (fifo_wr) wr_mod <= wr_mod + 1'b1;
    end

    AST_BURST_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && !$past(fifo_wr)) |-> $past(in_valid)); // R2
    AST_DROP_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> $past(in_valid)); // R4
    AST_MISALIGN_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
        misalign_pulse |-> $past(in_valid && in_eop)); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |->
            (drop_pulse && (drop_count == CNT_W'($past(drop_count) + 1'b1)))); // R7
    AST_COUNT_HOLD_MAX: assert property (@(posedge clk) disable iff (rst)
        (drop_count == '1) |=> (drop_count == '1)); // R7

    if (CHUNKING_EN) begin : g_chunk_props
        AST_WHOLE_BURSTS: assert property (@(posedge clk) disable iff (rst)
            $fell(fifo_wr) |-> (wr_mod == '0)); // R2
    end else begin : g_pt_props
        AST_PT_QUIET: assert property (@(posedge clk) disable iff (rst)
            !drop_pulse && !misalign_pulse && (drop_count == '0)); // R8
    end
endmodule

bind iso_chunk_gate iso_chunk_gate_chk #(
    .CHUNK_BYTES(CHUNK_BYTES), .CNT_W(CNT_W), .CHUNKING_EN(CHUNKING_EN)
) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_eop(in_eop),
    .fifo_wr(fifo_wr), .drop_pulse(drop_pulse),
    .misalign_pulse(misalign_pulse), .drop_count(drop_count)
);

// File: tb/iso_chunk_gate_tb.sv
`timescale 1ns/1ps
module iso_chunk_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic [9:0] fifo_free = '0;
    logic       fifo_wr, drop_pulse, misalign_pulse;
    logic [7:0] fifo_wdata;
    logic [15:0] drop_count;
    logic       pt_wr, pt_drop, pt_mis;
    logic [7:0] pt_data;
    logic [15:0] pt_count;

    always #2.5 clk = ~clk;

    iso_chunk_gate dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .fifo_free(fifo_free),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .drop_pulse(drop_pulse),
        .misalign_pulse(misalign_pulse), .drop_count(drop_count)
    );

    iso_chunk_gate #(.CHUNKING_EN(1'b0)) dut_pt_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .fifo_free(fifo_free),
        .fifo_wr(pt_wr), .fifo_wdata(pt_data), .drop_pulse(pt_drop),
        .misalign_pulse(pt_mis), .drop_count(pt_count)
    );

    int errors = 0;
    int checks = 0;
    int wr_seen = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [7:0] wq[$];
    logic [7:0] cur[$];
    int  m_pos = 0;
    bit  m_keep = 0;
    bit  e_drop = 0, e_mis = 0;
    int  e_cnt = 0;
    bit  e_pt_wr = 0;
    logic [7:0] e_pt_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            wq.delete(); cur.delete();
            m_pos = 0; m_keep = 0; e_drop = 0; e_mis = 0; e_cnt = 0;
            e_pt_wr = 0; e_pt_data = '0;
        end else begin
            int owed;
            int ep;
            owed = wq.size();
            if (wq.size() > 0) void'(wq.pop_front());
            e_drop = 0; e_mis = 0;
            e_pt_wr = in_valid; e_pt_data = in_data;
            if (in_valid) begin
                ep = in_sop ? 0 : m_pos;
                if (ep == 0) begin
                    cur.delete();
                    m_keep = (int'(fifo_free) >= 32 + owed);
                    if (!m_keep) begin
                        e_drop = 1;
                        if (e_cnt < 65535) e_cnt++;
                    end
                end
                if (m_keep) cur.push_back(in_data);
                if (ep == 31) begin
                    if (m_keep) foreach (cur[i]) wq.push_back(cur[i]);
                    m_pos = 0;
                end else if (in_eop) begin
                    e_mis = 1;
                    m_pos = 0;
                end else begin
                    m_pos = ep + 1;
                end
            end
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            bit e_wr;
            e_wr = (wq.size() > 0);
            chk(fifo_wr == e_wr, "R2 write strobe", fifo_wr, e_wr);
            if (e_wr) chk(fifo_wdata == wq[0], "R2 write data", fifo_wdata, wq[0]);
            chk(drop_pulse == e_drop, "R4 drop pulse", drop_pulse, e_drop);
            chk(misalign_pulse == e_mis, "R5 misalign pulse", misalign_pulse, e_mis);
            chk(drop_count == 16'(e_cnt), "R7 drop count", drop_count, e_cnt);
            chk(pt_wr == e_pt_wr, "R8 passthrough strobe", pt_wr, e_pt_wr);
            if (e_pt_wr) chk(pt_data == e_pt_data, "R8 passthrough data", pt_data, e_pt_data);
            chk(!pt_drop && !pt_mis && pt_count == 0, "R8 passthrough quiet",
                {pt_drop, pt_mis, pt_count}, 0);
            if (fifo_wr) wr_seen++;
        end
    end

    logic [7:0] seed = 8'h11;

    task automatic send_pkt(input int n, input int free_first, input int free_rest,
                            input int gap, input bit with_eop);
        for (int i = 0; i < n; i++) begin
            in_valid  = 1'b1;
            in_sop    = (i == 0);
            in_eop    = with_eop && (i == n - 1);
            in_data   = seed;
            seed      = seed * 8'd5 + 8'd3;
            fifo_free = 10'((i == 0) ? free_first : free_rest);
            @(negedge clk);
            if (gap > 0) begin
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!fifo_wr && !drop_pulse && !misalign_pulse && drop_count == 0,
            "R1 reset state", {fifo_wr, drop_pulse, misalign_pulse, drop_count}, 0);
        cmp_on = 1;

        // Two full chunks with ample room
        base = wr_seen; send_pkt(64, 1000, 1000, 0, 1); idle(40);
        chk(wr_seen - base == 64, "R2 two chunks written", wr_seen - base, 64);

        // Packet ending mid-chunk: tail discarded
        base = wr_seen; send_pkt(40, 1000, 1000, 0, 1); idle(40);
        chk(wr_seen - base == 32, "R5 partial tail not written", wr_seen - base, 32);

        // Second chunk meets bytes still owed by the first
        base = wr_seen; send_pkt(64, 40, 40, 0, 1); idle(40);
        chk(wr_seen - base == 32, "R3 owed bytes counted", wr_seen - base, 32);

        // One short of room
        base = wr_seen; send_pkt(32, 31, 1000, 0, 1); idle(40);
        chk(wr_seen - base == 0, "R4 dropped chunk not written", wr_seen - base, 0);

        // Decision held although room vanishes after the first byte
        base = wr_seen; send_pkt(32, 100, 0, 0, 1); idle(40);
        chk(wr_seen - base == 32, "R3 decision held (kept)", wr_seen - base, 32);
        base = wr_seen; send_pkt(32, 0, 1000, 0, 1); idle(40);
        chk(wr_seen - base == 0, "R3 decision held (dropped)", wr_seen - base, 0);

        // Gaps between bytes
        base = wr_seen; send_pkt(32, 1000, 1000, 1, 1); idle(40);
        chk(wr_seen - base == 32, "R9 gapped chunk", wr_seen - base, 32);
        base = wr_seen; send_pkt(64, 1000, 1000, 3, 1); idle(40);
        chk(wr_seen - base == 64, "R9 gapped two chunks", wr_seen - base, 64);

        // Start marker mid-chunk restarts the position
        base = wr_seen; send_pkt(20, 1000, 1000, 0, 0); send_pkt(32, 1000, 1000, 0, 1); idle(40);
        chk(wr_seen - base == 32, "R6 restart on start marker", wr_seen - base, 32);

        // Saturation of the drop counter with single-byte packets
        for (int k = 0; k < 65540; k++) send_pkt(1, 0, 0, 0, 1);
        idle(3);
        chk(drop_count == 16'hFFFF, "R7 saturated", drop_count, 16'hFFFF);

        rst = 1'b1; idle(2); rst = 1'b0;
        chk(drop_count == 0 && !fifo_wr, "R7 cleared by reset", drop_count, 0);
        idle(5);

        cmp_on = 0;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule